// File: doc/BRIEF.md
# Dual-Port RAM with Collision Arbitration and Mailbox Flags

This block is a shared memory of 2048 bytes that two independent agents, a left port and a right port, can reach at the same time. Each port has its own address, write data, read data, chip select, read/not-write select and output enable. The bidirectional data pins are modelled as separate input and output buses. A tri-stated output is modelled as a read-valid flag held low. All ports are sampled on one shared clock.

When both ports select the same location and at least one of them is writing, the block grants the location to the port that was there first. It raises a busy flag toward the other port. While a port sees busy, its writes are discarded; its reads still return the stored byte, but with the valid flag low. Two simultaneous reads of one location never contend.

The two highest addresses also act as mailboxes. Writing the top address from the left port raises an interrupt flag on the right port, and the right port clears it by reading that address. The address just below the top works the same way in the other direction.

Top module: `dpram_arb`

## Requirements
- R1: A byte written through either port can be read back through either port. Read data appears on the port's read bus on the clock edge after the read request.
- R2: A port's read-valid output is high in a cycle only if, in the previous cycle, that port had select high, output enable high, read/not-write high (1 = read, 0 = write) and busy low. In every other case it is low, including when the port is deselected.
- R3: When both ports read the same address in the same cycle, neither port sees busy and both receive the stored byte with valid high.
- R4: Contention exists when both selects are high, the addresses are equal and at least one port is writing. Busy is combinational and goes to the port that arrived later. A port has arrived earlier if it was selected at that same address in the previous cycle and the other port was not.
- R5: When both ports arrive at a contended address in the same cycle, the left port wins and the right port sees busy.
- R6: Busy falls in the same cycle in which the two addresses stop matching.
- R7: A write from a port that sees busy leaves the memory unchanged.
- R8: A read from a port that sees busy still places the stored byte on its read bus on the next edge, with valid low.
- R9: A left-port write to address 0x7FF that is not busy sets the right interrupt flag from the next cycle. A right-port read of 0x7FF that is not busy clears it. Reading any other address leaves the flag unchanged.
- R10: A right-port write to address 0x7FE that is not busy sets the left interrupt flag from the next cycle. A left-port read of 0x7FE that is not busy clears it.
- R11: After reset, both busy flags, both valid flags and both interrupt flags are low.
- R12: In one cycle, both ports may write different addresses, and both writes take effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared clock |
| rst_n | input | 1 | Active-low synchronous reset |
| l_addr | input | 11 | Left address |
| l_wdata | input | 8 | Left write data |
| l_sel | input | 1 | Left chip select, active high |
| l_rnw | input | 1 | Left 1 = read, 0 = write |
| l_oe | input | 1 | Left output enable, active high |
| l_rdata | output | 8 | Left read data |
| l_rvalid | output | 1 | Left read data valid |
| l_busy | output | 1 | Left loses a contended location |
| l_irq | output | 1 | Left mailbox interrupt |
| r_addr | input | 11 | Right address |
| r_wdata | input | 8 | Right write data |
| r_sel | input | 1 | Right chip select, active high |
| r_rnw | input | 1 | Right 1 = read, 0 = write |
| r_oe | input | 1 | Right output enable, active high |
| r_rdata | output | 8 | Right read data |
| r_rvalid | output | 1 | Right read data valid |
| r_busy | output | 1 | Right loses a contended location |
| r_irq | output | 1 | Right mailbox interrupt |

## Verification
The bench creates contention in both orders: one port holds an address for a cycle before the other arrives. A design that ignored arrival history would flag the wrong port. It also creates a same-cycle tie, where a missing tie-break would make both or neither port busy. After a suppressed write, the bench reads the location back; a design that let the losing write through would return the new byte. The bench also checks shared reads, which must not flag busy, and mailbox flags, which a design might clear on a read of the neighbouring address or set from the wrong port.

// File: rtl/dpram_pkg.sv
package dpram_pkg;
   // Address of the mailbox that notifies the right port (top word).
   function automatic int unsigned mbox_to_right(input int unsigned aw);
      return (1 << aw) - 1;
   endfunction
   // Address of the mailbox that notifies the left port (word below top).
   function automatic int unsigned mbox_to_left(input int unsigned aw);
      return (1 << aw) - 2;
   endfunction
   typedef enum logic {OWN_LEFT = 1'b0, OWN_RIGHT = 1'b1} owner_e;
endpackage

// File: rtl/dpram_store.sv
module dpram_store #(
   parameter int ADDR_W = 11,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              a_wr,
   input  logic              a_rd,
   input  logic [ADDR_W-1:0] a_addr,
   input  logic [DATA_W-1:0] a_wdata,
   output logic [DATA_W-1:0] a_rdata,
   input  logic              b_wr,
   input  logic              b_rd,
   input  logic [ADDR_W-1:0] b_addr,
   input  logic [DATA_W-1:0] b_wdata,
   output logic [DATA_W-1:0] b_rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] cells [DEPTH];

   // Arbitration guarantees the two write addresses never coincide.
   always_ff @(posedge clk) begin
      if (a_wr) cells[a_addr] <= a_wdata;
      if (b_wr) cells[b_addr] <= b_wdata;
   end

   // Read-before-write: a read returns the contents prior to this edge.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         a_rdata <= '0;
         b_rdata <= '0;
      end else begin
         if (a_rd) a_rdata <= cells[a_addr];
         if (b_rd) b_rdata <= cells[b_addr];
      end
   end
endmodule

// File: rtl/dpram_arbiter.sv
module dpram_arbiter
   import dpram_pkg::*;
#(
   parameter int ADDR_W   = 11,
   parameter bit TIE_LEFT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              l_sel,
   input  logic              l_rnw,
   input  logic [ADDR_W-1:0] l_addr,
   input  logic              r_sel,
   input  logic              r_rnw,
   input  logic [ADDR_W-1:0] r_addr,
   output logic              l_busy,
   output logic              r_busy
);
   logic              l_sel_q, r_sel_q;
   logic [ADDR_W-1:0] l_addr_q, r_addr_q;
   logic              clash, clash_q;
   owner_e            owner, owner_q;
   owner_e            tie_owner;
   logic              l_stayed, r_stayed;

   generate
      if (TIE_LEFT) begin : g_tie_left
         assign tie_owner = OWN_LEFT;
      end else begin : g_tie_right
         assign tie_owner = OWN_RIGHT;
      end
   endgenerate

   assign clash    = l_sel && r_sel && (l_addr == r_addr) && (!l_rnw || !r_rnw);
   assign l_stayed = l_sel_q && (l_addr_q == l_addr);
   assign r_stayed = r_sel_q && (r_addr_q == r_addr);

   always_comb begin
      if (clash_q)                     owner = owner_q;
      else if (l_stayed && !r_stayed)  owner = OWN_LEFT;
      else if (r_stayed && !l_stayed)  owner = OWN_RIGHT;
      else                             owner = tie_owner;
   end

   assign l_busy = clash && (owner == OWN_RIGHT);
   assign r_busy = clash && (owner == OWN_LEFT);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         l_sel_q  <= 1'b0;
         r_sel_q  <= 1'b0;
         l_addr_q <= '0;
         r_addr_q <= '0;
         clash_q  <= 1'b0;
         owner_q  <= OWN_LEFT;
      end else begin
         l_sel_q  <= l_sel;
         r_sel_q  <= r_sel;
         l_addr_q <= l_addr;
         r_addr_q <= r_addr;
         clash_q  <= clash;
         owner_q  <= owner;
      end
   end
endmodule

// File: rtl/dpram_port.sv
module dpram_port (
   input  logic clk,
   input  logic rst_n,
   input  logic sel,
   input  logic rnw,
   input  logic oe,
   input  logic busy,
   output logic wr_go,
   output logic rd_go,
   output logic rd_ok,
   output logic rvalid
);
   assign wr_go = sel && !rnw && !busy;
   assign rd_go = sel && rnw;
   assign rd_ok = rd_go && !busy;

   always_ff @(posedge clk) begin
      if (!rst_n) rvalid <= 1'b0;
      else        rvalid <= rd_ok && oe;
   end
endmodule

// File: rtl/dpram_mailbox.sv
module dpram_mailbox (
   input  logic clk,
   input  logic rst_n,
   input  logic post,
   input  logic take,
   output logic flag
);
   always_ff @(posedge clk) begin
      if (!rst_n)    flag <= 1'b0;
      else if (post) flag <= 1'b1;
      else if (take) flag <= 1'b0;
   end
endmodule

// File: rtl/dpram_arb.sv
module dpram_arb
   import dpram_pkg::*;
#(
   parameter int ADDR_W   = 11,
   parameter int DATA_W   = 8,
   parameter bit TIE_LEFT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] l_addr,
   input  logic [DATA_W-1:0] l_wdata,
   input  logic              l_sel,
   input  logic              l_rnw,
   input  logic              l_oe,
   output logic [DATA_W-1:0] l_rdata,
   output logic              l_rvalid,
   output logic              l_busy,
   output logic              l_irq,
   input  logic [ADDR_W-1:0] r_addr,
   input  logic [DATA_W-1:0] r_wdata,
   input  logic              r_sel,
   input  logic              r_rnw,
   input  logic              r_oe,
   output logic [DATA_W-1:0] r_rdata,
   output logic              r_rvalid,
   output logic              r_busy,
   output logic              r_irq
);
   localparam logic [ADDR_W-1:0] BOX_R = ADDR_W'(mbox_to_right(ADDR_W));
   localparam logic [ADDR_W-1:0] BOX_L = ADDR_W'(mbox_to_left(ADDR_W));

   generate
      if (ADDR_W < 2 || ADDR_W > 16) begin : g_bad_addr_w
         $error("dpram_arb: ADDR_W must lie in 2..16");
      end
      if (DATA_W < 1) begin : g_bad_data_w
         $error("dpram_arb: DATA_W must be positive");
      end
   endgenerate

   logic l_wr_go, l_rd_go, l_rd_ok;
   logic r_wr_go, r_rd_go, r_rd_ok;

   dpram_arbiter #(.ADDR_W(ADDR_W), .TIE_LEFT(TIE_LEFT)) arb_i (
      .clk(clk), .rst_n(rst_n),
      .l_sel(l_sel), .l_rnw(l_rnw), .l_addr(l_addr),
      .r_sel(r_sel), .r_rnw(r_rnw), .r_addr(r_addr),
      .l_busy(l_busy), .r_busy(r_busy)
   );

   dpram_port l_port_i (
      .clk(clk), .rst_n(rst_n), .sel(l_sel), .rnw(l_rnw), .oe(l_oe),
      .busy(l_busy), .wr_go(l_wr_go), .rd_go(l_rd_go), .rd_ok(l_rd_ok),
      .rvalid(l_rvalid)
   );

   dpram_port r_port_i (
      .clk(clk), .rst_n(rst_n), .sel(r_sel), .rnw(r_rnw), .oe(r_oe),
      .busy(r_busy), .wr_go(r_wr_go), .rd_go(r_rd_go), .rd_ok(r_rd_ok),
      .rvalid(r_rvalid)
   );

   dpram_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) store_i (
      .clk(clk), .rst_n(rst_n),
      .a_wr(l_wr_go), .a_rd(l_rd_go), .a_addr(l_addr), .a_wdata(l_wdata),
      .a_rdata(l_rdata),
      .b_wr(r_wr_go), .b_rd(r_rd_go), .b_addr(r_addr), .b_wdata(r_wdata),
      .b_rdata(r_rdata)
   );

   dpram_mailbox to_right_i (
      .clk(clk), .rst_n(rst_n),
      .post(l_wr_go && (l_addr == BOX_R)),
      .take(r_rd_ok && (r_addr == BOX_R)),
      .flag(r_irq)
   );

   dpram_mailbox to_left_i (
      .clk(clk), .rst_n(rst_n),
      .post(r_wr_go && (r_addr == BOX_L)),
      .take(l_rd_ok && (l_addr == BOX_L)),
      .flag(l_irq)
   );
endmodule

// File: rtl/dpram_arb_chk.sv
module dpram_arb_chk #(
   parameter int ADDR_W = 11
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] l_addr,
   input logic              l_sel,
   input logic              l_rnw,
   input logic              l_oe,
   input logic              l_rvalid,
   input logic              l_busy,
   input logic [ADDR_W-1:0] r_addr,
   input logic              r_sel,
   input logic              r_rnw,
   input logic              r_oe,
   input logic              r_rvalid,
   input logic              r_busy,
   input logic              r_irq
);
   localparam logic [ADDR_W-1:0] TOP = '1;

   // R4
   one_loser_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(l_busy && r_busy));

   // R6
   busy_needs_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (l_busy || r_busy) |-> (l_sel && r_sel && l_addr == r_addr));

   // R3
   shared_read_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (l_sel && r_sel && l_rnw && r_rnw) |-> !(l_busy || r_busy));

   // R2
   l_valid_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      l_rvalid |-> $past(l_sel && l_oe && l_rnw && !l_busy));

   // R2
   r_valid_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      r_rvalid |-> $past(r_sel && r_oe && r_rnw && !r_busy));

   // R9
   r_irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(r_irq) |-> $past(l_sel && !l_rnw && !l_busy && l_addr == TOP));
endmodule

bind dpram_arb dpram_arb_chk #(.ADDR_W(ADDR_W)) chk_i (
   .clk(clk), .rst_n(rst_n),
   .l_addr(l_addr), .l_sel(l_sel), .l_rnw(l_rnw), .l_oe(l_oe),
   .l_rvalid(l_rvalid), .l_busy(l_busy),
   .r_addr(r_addr), .r_sel(r_sel), .r_rnw(r_rnw), .r_oe(r_oe),
   .r_rvalid(r_rvalid), .r_busy(r_busy), .r_irq(r_irq)
);

// File: tb/dpram_arb_tb.sv
module dpram_arb_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [10:0] l_addr = '0, r_addr = '0;
   logic [7:0]  l_wdata = '0, r_wdata = '0;
   logic        l_sel = 0, l_rnw = 1, l_oe = 0;
   logic        r_sel = 0, r_rnw = 1, r_oe = 0;
   logic [7:0]  l_rdata, r_rdata;
   logic        l_rvalid, l_busy, l_irq, r_rvalid, r_busy, r_irq;

   int n_run = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   dpram_arb dut_i (
      .clk(clk), .rst_n(rst_n),
      .l_addr(l_addr), .l_wdata(l_wdata), .l_sel(l_sel), .l_rnw(l_rnw),
      .l_oe(l_oe), .l_rdata(l_rdata), .l_rvalid(l_rvalid),
      .l_busy(l_busy), .l_irq(l_irq),
      .r_addr(r_addr), .r_wdata(r_wdata), .r_sel(r_sel), .r_rnw(r_rnw),
      .r_oe(r_oe), .r_rdata(r_rdata), .r_rvalid(r_rvalid),
      .r_busy(r_busy), .r_irq(r_irq)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // Drive inputs at the falling edge.
   task automatic lset(input bit s, input bit rd, input bit oe,
                       input int a, input int d);
      l_sel = s; l_rnw = rd; l_oe = oe; l_addr = 11'(a); l_wdata = 8'(d);
   endtask
   task automatic rset(input bit s, input bit rd, input bit oe,
                       input int a, input int d);
      r_sel = s; r_rnw = rd; r_oe = oe; r_addr = 11'(a); r_wdata = 8'(d);
   endtask

   // Advance to the next falling edge (one rising edge in between).
   task automatic step();
      @(negedge clk);
   endtask

   task automatic idle();
      lset(0, 1, 0, 0, 0); rset(0, 1, 0, 0, 0); step();
   endtask

   task automatic wr_left(input int a, input int d);
      lset(1, 0, 0, a, d); rset(0, 1, 0, 0, 0); step(); idle();
   endtask

   task automatic rd_left_exp(input int a, input int d, input string req);
      lset(1, 1, 1, a, 0); rset(0, 1, 0, 0, 0); step();
      chk(req, l_rdata, d); chk(req, l_rvalid, 1);
      idle();
   endtask

   task automatic t_reset();
      chk("R11 l_busy", l_busy, 0);   chk("R11 r_busy", r_busy, 0);
      chk("R11 l_rvalid", l_rvalid, 0); chk("R11 r_rvalid", r_rvalid, 0);
      chk("R11 l_irq", l_irq, 0);     chk("R11 r_irq", r_irq, 0);
   endtask

   task automatic t_basic();
      // R12: both ports write different addresses in one cycle
      lset(1, 0, 0, 'h010, 'hA5); rset(1, 0, 0, 'h020, 'h3C); #1;
      chk("R12 no busy", int'(l_busy | r_busy), 0);
      step(); idle();
      // R1: cross read-back, one clock latency
      lset(1, 1, 1, 'h020, 0); rset(1, 1, 1, 'h010, 0); step();
      chk("R1 left data", l_rdata, 'h3C); chk("R1 left valid", l_rvalid, 1);
      chk("R1 right data", r_rdata, 'hA5); chk("R1 right valid", r_rvalid, 1);
      idle();
   endtask

   task automatic t_valid();
      // R2: output enable low
      lset(1, 1, 0, 'h010, 0); step();
      chk("R2 oe low", l_rvalid, 0);
      // R2: deselected
      lset(0, 1, 1, 'h010, 0); step();
      chk("R2 deselected", l_rvalid, 0);
      // R2: write cycle
      lset(1, 0, 1, 'h011, 'h01); step();
      chk("R2 write", l_rvalid, 0);
      idle();
   endtask

   task automatic t_shared_read();
      lset(1, 1, 1, 'h010, 0); rset(1, 1, 1, 'h010, 0); #1;
      chk("R3 no busy", int'(l_busy | r_busy), 0);
      step();
      chk("R3 left", l_rdata, 'hA5); chk("R3 left valid", l_rvalid, 1);
      chk("R3 right", r_rdata, 'hA5); chk("R3 right valid", r_rvalid, 1);
      idle();
   endtask

   task automatic t_left_first();
      wr_left('h030, 'h11);
      lset(1, 1, 1, 'h030, 0); step();            // left arrives first
      rset(1, 0, 0, 'h030, 'hFF); #1;             // right writes later
      chk("R4 right busy", r_busy, 1); chk("R4 left free", l_busy, 0);
      step();
      rset(1, 0, 0, 'h031, 'hFF); #1;             // addresses differ
      chk("R6 busy released", r_busy, 0);
      idle();
      rd_left_exp('h030, 'h11, "R7 suppressed right write");
   endtask

   task automatic t_busy_read();
      lset(1, 0, 0, 'h040, 'h22); step();         // left writes first
      rset(1, 1, 1, 'h040, 0); #1;
      chk("R8 right busy", r_busy, 1);
      step();
      chk("R8 data on busy read", r_rdata, 'h22);
      chk("R8 valid low", r_rvalid, 0);
      idle();
   endtask

   task automatic t_right_first();
      wr_left('h050, 'h5A);
      rset(1, 1, 1, 'h050, 0); step();            // right arrives first
      lset(1, 0, 0, 'h050, 'h99); #1;
      chk("R4 left busy", l_busy, 1); chk("R4 right free", r_busy, 0);
      step(); idle();
      rd_left_exp('h050, 'h5A, "R7 suppressed left write");
   endtask

   task automatic t_tie();
      wr_left('h060, 'h12);
      lset(1, 1, 1, 'h060, 0); rset(1, 0, 0, 'h060, 'h77); #1;
      chk("R5 right busy", r_busy, 1); chk("R5 left free", l_busy, 0);
      step(); idle();
      rd_left_exp('h060, 'h12, "R5 tie write dropped");
   endtask

   task automatic t_mail();
      wr_left('h7FF, 'h01);
      chk("R9 right irq set", r_irq, 1); chk("R9 left irq quiet", l_irq, 0);
      rset(1, 1, 1, 'h7FE, 0); step(); idle();
      chk("R9 other read keeps", r_irq, 1);
      rset(1, 1, 1, 'h7FF, 0); step(); idle();
      chk("R9 right irq cleared", r_irq, 0);
      rset(1, 0, 0, 'h7FE, 'h02); step(); idle();
      chk("R10 left irq set", l_irq, 1); chk("R10 right irq quiet", r_irq, 0);
      lset(1, 1, 1, 'h7FE, 0); step(); idle();
      chk("R10 left irq cleared", l_irq, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      step();
      t_reset();
      t_basic();
      t_valid();
      t_shared_read();
      t_left_first();
      t_busy_read();
      t_right_first();
      t_tie();
      t_mail();
      $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_run++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
   end
endmodule